// File: doc/BRIEF.md
# Staged Pixel Clock Divider

This block turns a fast system clock into a panel pixel-clock enable. A programmable integer divider produces one pulse every N source periods. A select bit chooses between two sources: the system clock itself, which is the doubled source, or a half-rate source taken from every second system cycle. A divider field below 2 is treated as 2. A polarity bit sets the level of a derived pixel clock, and that level is also the clock's idle level. All three fields live in one configuration word, which is written through a per-bit mask so that a single field can change without touching the others.

The block also brings three output stages up and down in sequence: the pixel clock, then sync generation, then display data. Software sets a stage by writing a one to a set-enable input and removes it by writing a one to a set-disable input. Both inputs use the same bit positions. A status vector shows which stages are actually running, and it lags each request by a fixed number of pixel periods. Software therefore raises one stage, polls status until it is up, and only then raises the next. Going down works the same way in reverse order. The hardware ignores an out-of-order enable. Disabling a lower stage drops the stages above it at once.

Top module: `pixclk_stager`

## Requirements
- R1: After reset, status is 0, pixEn is 0, pixClk is 0 and the configuration word reads 0.
- R2: Configuration word layout: bit 0 is polarity, bit 1 is the doubled-source select, and bits [DIV_W+1:2] are the divider. While the pixel stage is up, pixEn pulses once every D×1 cycles when the select is 1 and once every D×2 cycles when it is 0. D is the effective divider.
- R3: A divider field of 0 or 1 gives an effective divider of 2.
- R4: A configuration write changes only the bits whose mask bit is 1. Readback equals (old & ~mask) | (data & mask).
- R5: When the effective divider changes, the count restarts. The first pixEn pulse comes exactly P+1 cycles after the write edge, where P is the new period. No shorter pulse gap is produced.
- R6: Stage bits are: bit 0 pixel clock, bit 1 sync, bit 2 display. Status uses the same positions. Pixel-stage status rises LAT_PIX×P cycles after the set write edge. After a disable, it falls on the edge of the LAT_PIX-th pixEn pulse.
- R7: Sync and display status each change on the edge of their LAT_SYNC-th or LAT_DISP-th pixEn pulse after the request, for both enable and disable.
- R8: A sync enable is ignored unless the pixel stage is requested and up. A display enable is ignored unless sync is requested and up.
- R9: Disabling a lower stage clears the status of every higher stage on the same edge.
- R10: When set and clear for one stage arrive in the same cycle, the clear wins.
- R11: pixEn pulses only while pixel-stage status is 1. When the pixel stage is down, pixClk sits at the polarity bit.
- R12: pixEn is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (the doubled source) |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrMask | input | DIV_W+2 | Per-bit write mask |
| cfgWrData | input | DIV_W+2 | Write data |
| enSet | input | 3 | Write-one stage enable requests |
| enClr | input | 3 | Write-one stage disable requests |
| cfgRd | output | DIV_W+2 | Current configuration word |
| status | output | 3 | Live stage status |
| pixEn | output | 1 | Pixel clock-enable pulse |
| pixClk | output | 1 | Derived pixel clock level |

## Verification
Two pairs of events can land in the same cycle. A set and a clear can target one stage together. A lower stage can be cleared while a higher stage is busy or up. The bench drives both requests in one write cycle and expects the clear to win. The affected status bit then falls exactly LAT pixel pulses later, while the display status bit drops on that very edge. A divider reload can also collide with a pulse that is due. The bench writes a new divider straight after a pulse and requires that the next pulse arrive exactly one full new period plus one cycle later.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int NUM_STAGES  = 3;
  localparam int STG_PIX     = 0;
  localparam int STG_SYNC    = 1;
  localparam int STG_DISP    = 2;
  localparam int CFG_POL_BIT = 0;
  localparam int CFG_DBL_BIT = 1;
  localparam int CFG_DIV_LSB = 2;

  // strobes from stage control to the divider datapath
  typedef struct packed {
    logic runDiv;   // divider counting
    logic gateOut;  // pixel outputs released
  } divCtrl_t;
endpackage

// File: rtl/pcd_divider.sv
module pcd_divider
  import pcd_pkg::*;
#(
  parameter int DIV_W = 8,
  localparam int CFG_W = DIV_W + CFG_DIV_LSB
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrMask,
  input  logic [CFG_W-1:0] cfgWrData,
  input  divCtrl_t         ctrl,
  output logic [CFG_W-1:0] cfgQ,
  output logic             divTick,
  output logic             pixEn,
  output logic             pixClk
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic [CFG_W-1:0] cfgR;
  logic [DIV_W-1:0] divField, divEff, divPrev, half, cntQ;
  logic             dbl, pol, phaseQ, srcTick, reload, lastCnt;
  logic             pixEnQ, pixClkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgR <= '0;
    else if (cfgWrEn) cfgR <= (cfgR & ~cfgWrMask) | (cfgWrData & cfgWrMask);
  end

  always_comb begin
    divField = cfgR[CFG_W-1:CFG_DIV_LSB];
    dbl      = cfgR[CFG_DBL_BIT];
    pol      = cfgR[CFG_POL_BIT];
    divEff   = (divField < DIV_MIN) ? DIV_MIN : divField;
    half     = divEff >> 1;
    reload   = (divEff != divPrev);
    srcTick  = dbl | phaseQ;
    lastCnt  = (cntQ == divEff - DIV_W'(1));
    divTick  = ctrl.runDiv && !reload && srcTick && lastCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divPrev <= DIV_MIN;
      cntQ    <= '0;
      phaseQ  <= 1'b0;
      pixEnQ  <= 1'b0;
      pixClkQ <= 1'b0;
    end else begin
      divPrev <= divEff;
      if (!ctrl.runDiv || reload) begin
        cntQ   <= '0;
        phaseQ <= 1'b0;
      end else begin
        phaseQ <= ~phaseQ;
        if (srcTick) cntQ <= lastCnt ? '0 : cntQ + DIV_W'(1);
      end
      pixEnQ  <= divTick && ctrl.gateOut;
      pixClkQ <= ctrl.gateOut ? ((cntQ < half) ^ pol) : pol;
    end
  end

  assign cfgQ   = cfgR;
  assign pixEn  = pixEnQ;
  assign pixClk = pixClkQ;

  AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    pixEn |=> !pixEn) else $error("pulse spacing");  // R12
  AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rstN)
    divTick |-> (cntQ != '0)) else $error("runt divide");  // R3
  AST_GATED_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pixEn |-> $past(ctrl.gateOut)) else $error("ungated pulse");  // R11
endmodule

// File: rtl/pcd_sequencer.sv
module pcd_sequencer
  import pcd_pkg::*;
#(
  parameter int LAT_PIX  = 2,
  parameter int LAT_SYNC = 3,
  parameter int LAT_DISP = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_STAGES-1:0] enSet,
  input  logic [NUM_STAGES-1:0] enClr,
  input  logic                  divTick,
  output divCtrl_t              ctrl,
  output logic [NUM_STAGES-1:0] status
);
  localparam int LAT_A   = (LAT_PIX > LAT_SYNC) ? LAT_PIX : LAT_SYNC;
  localparam int LAT_MAX = (LAT_A > LAT_DISP) ? LAT_A : LAT_DISP;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);

  function automatic logic [LAT_W-1:0] latOf(input int idx);
    case (idx)
      STG_PIX:  return LAT_W'(LAT_PIX);
      STG_SYNC: return LAT_W'(LAT_SYNC);
      default:  return LAT_W'(LAT_DISP);
    endcase
  endfunction

  logic [NUM_STAGES-1:0] reqQ, statQ, killIn, gateOk;
  logic [LAT_W-1:0]      waitQ [NUM_STAGES];

  for (genvar g = 0; g < NUM_STAGES; g++) begin : gStage
    if (g == 0) begin : gBase
      assign killIn[g] = 1'b0;
      assign gateOk[g] = 1'b1;
    end else begin : gUpper
      assign killIn[g] = |enClr[g-1:0];
      assign gateOk[g] = reqQ[g-1] & statQ[g-1];

      AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
        statQ[g] |-> statQ[g-1]) else $error("stage order");  // R8
      AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
        $rose(statQ[g]) |-> $past(divTick)) else $error("early status");  // R7
      AST_KILL_HIGHER: assert property (@(posedge clk) disable iff (!rstN)
        enClr[g-1] |=> !statQ[g]) else $error("higher stage kept");  // R9
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (enSet[g] && enClr[g]) |=> !reqQ[g]) else $error("set beat clear");  // R10
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ  <= '0;
      statQ <= '0;
      for (int i = 0; i < NUM_STAGES; i++) waitQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_STAGES; i++) begin
        if (killIn[i]) begin
          reqQ[i]  <= 1'b0;
          statQ[i] <= 1'b0;
          waitQ[i] <= '0;
        end else if (enClr[i]) begin
          if (reqQ[i]) begin
            reqQ[i]  <= 1'b0;
            waitQ[i] <= latOf(i);
          end
        end else if (enSet[i] && gateOk[i] && !reqQ[i]) begin
          reqQ[i]  <= 1'b1;
          waitQ[i] <= latOf(i);
        end else if ((reqQ[i] != statQ[i]) && divTick) begin
          if (waitQ[i] <= LAT_W'(1)) begin
            statQ[i] <= reqQ[i];
            waitQ[i] <= '0;
          end else begin
            waitQ[i] <= waitQ[i] - LAT_W'(1);
          end
        end
      end
    end
  end

  assign ctrl.runDiv  = reqQ[STG_PIX] | statQ[STG_PIX];
  assign ctrl.gateOut = statQ[STG_PIX];
  assign status       = statQ;

  AST_PIX_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statQ[STG_PIX]) |-> $past(divTick)) else $error("early pixel off");  // R6
endmodule

// File: rtl/pixclk_stager.sv
module pixclk_stager
  import pcd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int LAT_PIX  = 2,
  parameter int LAT_SYNC = 3,
  parameter int LAT_DISP = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWrEn,
  input  logic [DIV_W+CFG_DIV_LSB-1:0]  cfgWrMask,
  input  logic [DIV_W+CFG_DIV_LSB-1:0]  cfgWrData,
  input  logic [NUM_STAGES-1:0]         enSet,
  input  logic [NUM_STAGES-1:0]         enClr,
  output logic [DIV_W+CFG_DIV_LSB-1:0]  cfgRd,
  output logic [NUM_STAGES-1:0]         status,
  output logic                          pixEn,
  output logic                          pixClk
);
  divCtrl_t divCtrl;
  logic     divTick;

  pcd_sequencer #(
    .LAT_PIX (LAT_PIX),
    .LAT_SYNC(LAT_SYNC),
    .LAT_DISP(LAT_DISP)
  ) uSeq (
    .clk    (clk),
    .rstN   (rstN),
    .enSet  (enSet),
    .enClr  (enClr),
    .divTick(divTick),
    .ctrl   (divCtrl),
    .status (status)
  );

  pcd_divider #(.DIV_W(DIV_W)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWrMask(cfgWrMask),
    .cfgWrData(cfgWrData),
    .ctrl     (divCtrl),
    .cfgQ     (cfgRd),
    .divTick  (divTick),
    .pixEn    (pixEn),
    .pixClk   (pixClk)
  );
endmodule

// File: tb/tb_pixclk_stager.sv
module tb_pixclk_stager;
  localparam int DIV_W    = 8;
  localparam int CFG_W    = DIV_W + 2;
  localparam int LAT_PIX  = 2;
  localparam int LAT_SYNC = 3;
  localparam int LAT_DISP = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic [CFG_W-1:0] cfgWrMask = '0;
  logic [CFG_W-1:0] cfgWrData = '0;
  logic [2:0]       enSet = '0;
  logic [2:0]       enClr = '0;
  logic [CFG_W-1:0] cfgRd;
  logic [2:0]       status;
  logic             pixEn;
  logic             pixClk;

  int errors = 0;
  int checks = 0;
  logic [CFG_W-1:0] cfgModel = '0;

  always #4 clk = ~clk;

  pixclk_stager #(.DIV_W(DIV_W), .LAT_PIX(LAT_PIX), .LAT_SYNC(LAT_SYNC),
                  .LAT_DISP(LAT_DISP)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrMask(cfgWrMask),
    .cfgWrData(cfgWrData), .enSet(enSet), .enClr(enClr), .cfgRd(cfgRd),
    .status(status), .pixEn(pixEn), .pixClk(pixClk));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expPeriod(input logic [CFG_W-1:0] c);
    int d = int'(c[CFG_W-1:2]);
    if (d < 2) d = 2;
    return c[1] ? d : 2 * d;
  endfunction

  function automatic logic [CFG_W-1:0] mkCfg(input int div, input bit dbl, input bit pol);
    return (CFG_W'(div) << 2) | (CFG_W'(dbl) << 1) | CFG_W'(pol);
  endfunction

  // all tasks are entered at a negedge; the write edge is the next posedge
  task automatic wrCfg(input logic [CFG_W-1:0] m, input logic [CFG_W-1:0] d);
    cfgWrEn = 1'b1; cfgWrMask = m; cfgWrData = d;
    cfgModel = (cfgModel & ~m) | (d & m);
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrMask = '0; cfgWrData = '0;
  endtask

  task automatic stageReq(input logic [2:0] s, input logic [2:0] c);
    enSet = s; enClr = c;
    @(negedge clk);
    enSet = '0; enClr = '0;
  endtask

  task automatic waitPulse();
    int n = 0;
    do begin @(negedge clk); n++; end while (!pixEn && n < 2000);
  endtask

  task automatic measure(output int p);
    waitPulse();
    waitPulse();
    p = 0;
    do begin @(negedge clk); p++; end while (!pixEn && p < 2000);
  endtask

  task automatic pulsesUntil(input int idx, input bit level, output int pulses);
    int n = 0;
    pulses = pixEn ? 1 : 0;
    while (status[idx] !== level && n < 5000) begin
      @(negedge clk); n++;
      if (pixEn) pulses++;
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int p, j, n, seedDummy;
    seedDummy = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(status == 3'b000, "R1 status", status, 0);
    check(pixEn == 1'b0, "R1 pixEn", pixEn, 0);
    check(pixClk == 1'b0, "R1 pixClk", pixClk, 0);
    check(cfgRd == '0, "R1 cfg", cfgRd, 0);

    // R4 masked write of the polarity bit only; R11 idle level
    wrCfg('1, mkCfg(5, 1'b1, 1'b0));
    wrCfg(CFG_W'(1), CFG_W'(1));
    check(cfgRd == mkCfg(5, 1'b1, 1'b1), "R4 masked pol write", cfgRd, mkCfg(5, 1'b1, 1'b1));
    @(negedge clk);
    check(pixClk == 1'b1, "R11 idle level follows polarity", pixClk, 1);

    // R8 sync enable ignored while pixel stage is down
    stageReq(3'b010, 3'b000);
    repeat (40) @(negedge clk);
    check(status == 3'b000, "R8 sync without pixel", status, 0);

    // R6 pixel stage rise time
    stageReq(3'b001, 3'b000);
    j = 1; n = 0;
    while (!status[0] && j < 5000) begin
      if (pixEn) n++;
      @(negedge clk); j++;
    end
    check(j - 1 == LAT_PIX * 5, "R6 pixel rise cycles", j - 1, LAT_PIX * 5);
    check(n == 0, "R11 no pulse before pixel up", n, 0);

    measure(p);
    check(p == 5, "R2 period div5 doubled", p, 5);

    // R8 display enable ignored while sync is down
    stageReq(3'b100, 3'b000);
    repeat (60) @(negedge clk);
    check(status == 3'b001, "R8 display without sync", status, 1);

    // R7 sync and display latencies
    waitPulse(); stageReq(3'b010, 3'b000);
    pulsesUntil(1, 1'b1, n);
    check(n == LAT_SYNC, "R7 sync on latency", n, LAT_SYNC);
    waitPulse(); stageReq(3'b100, 3'b000);
    pulsesUntil(2, 1'b1, n);
    check(n == LAT_DISP, "R7 display on latency", n, LAT_DISP);

    // R10 clear wins on sync; R9 display dropped on the same edge
    waitPulse(); stageReq(3'b010, 3'b010);
    check(status == 3'b011, "R9 display forced off", status, 3);
    pulsesUntil(1, 1'b0, n);
    check(n == LAT_SYNC, "R10 clear wins, sync off latency", n, LAT_SYNC);

    // R10 set and clear together on a stage that is off
    waitPulse(); stageReq(3'b010, 3'b000);
    pulsesUntil(1, 1'b1, n);
    stageReq(3'b100, 3'b100);
    repeat (60) @(negedge clk);
    check(status == 3'b011, "R10 collision on idle display", status, 3);

    // R5 reload on divider change
    waitPulse();
    wrCfg('1, mkCfg(7, 1'b1, 1'b1));
    j = 1;
    while (!pixEn && j < 2000) begin @(negedge clk); j++; end
    check(j - 1 == expPeriod(cfgModel) + 1, "R5 first pulse after reload", j - 1, expPeriod(cfgModel) + 1);
    measure(p);
    check(p == 7, "R2 period div7 doubled", p, 7);

    // R3 clamp of tiny divider fields
    wrCfg('1, mkCfg(0, 1'b1, 1'b1));
    measure(p);
    check(p == 2, "R3 div0 clamps", p, 2);
    wrCfg('1, mkCfg(1, 1'b0, 1'b1));
    measure(p);
    check(p == 4, "R3 div1 clamps half-rate", p, 4);

    // R2 R4 R12 random masked writes
    for (int it = 0; it < 24; it++) begin
      logic [CFG_W-1:0] m, d;
      m = CFG_W'($urandom);
      d = CFG_W'($urandom);
      d[CFG_W-1:6] = '0;
      m[1] = m[1] | (it < 3);
      wrCfg(m, d);
      check(cfgRd == cfgModel, "R4 random masked write", cfgRd, cfgModel);
      measure(p);
      check(p == expPeriod(cfgModel), "R2 random period", p, expPeriod(cfgModel));
      check(p >= 2, "R12 pulse spacing", p, 2);
    end

    // R9 R6 R11 pixel stage down
    waitPulse(); stageReq(3'b000, 3'b001);
    check(status == 3'b001, "R9 upper stages forced off", status, 1);
    pulsesUntil(0, 1'b0, n);
    check(n == LAT_PIX, "R6 pixel off latency", n, LAT_PIX);
    @(negedge clk);
    n = 0;
    for (int k = 0; k < 60; k++) begin
      if (pixEn) n++;
      @(negedge clk);
    end
    check(n == 0, "R11 no pulses when down", n, 0);
    check(pixClk == cfgModel[0], "R11 idle level", pixClk, cfgModel[0]);

    finishRun();
  end
endmodule